// File: doc/BRIEF.md
# Two-Stage Programmable Clock Prescaler

This block turns a fast input clock into a sparse train of single-cycle enable pulses, all in the input clock domain. The division factor is the product of two programmable stages. The first is a power-of-two stage that divides by 2^(N+1). The second is a linear stage that divides by (M+1). The output therefore pulses once every 2^(N+1) × (M+1) input cycles.

Both factors sit in one 32-bit configuration word, which is loaded through a simple write strobe and can be read back at any time. Every write restarts both stage counters, so the new rate takes effect from a known phase. A separate select input decides what a downstream peripheral, such as a timer, receives. When the select is set it gets the prescaled pulse. When it is clear it gets a permanent enable, which means it runs at the raw input rate.

Top module: `tick_prescaler`

## Requirements
- R1: While reset is asserted and after its release, the configuration read-back is 0x0000_1009 (N=1, M=9) and `tick_o` is low until the first full period has elapsed.
- R2: In steady state, consecutive `tick_o` pulses are exactly 2^(N+1) × (M+1) input cycles apart.
- R3: `tick_o` is high for exactly one input cycle per period.
- R4: A write restarts both stages, including a write mid-period or of an unchanged value. The write is sampled at clock edge E, and the first pulse after it is seen just after edge E+P, where P is the new period. No pulse is seen in the cycle right after the write.
- R5: Bits [31:16] of the written word are reserved. They read back as zero and have no effect on the period.
- R6: N is taken from bits [15:12] and M from bits [11:0]. The read-back equals bits [15:0] of the last accepted write and holds when no write occurs.
- R7: With N=0 and M=0 the pulse occurs on every second input cycle.
- R8: With `use_prescaled` high, `periph_en_o` follows `tick_o`. With it low, `periph_en_o` is constantly high (raw input rate).
- R9: The reset configuration divides by 40, so the first pulse after reset release appears just after the 40th rising edge.
- R10: Field extremes are honoured: M=2593 (0xA21) with N=1 gives a period of 10376, and N=15 with M=0 gives a period of 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: N in [15:12], M in [11:0] |
| cfg_rdata | output | 32 | Current configuration, reserved bits zero |
| use_prescaled | input | 1 | 1: peripheral gets the prescaled pulse, 0: raw rate |
| tick_o | output | 1 | One-cycle prescaled enable pulse |
| periph_en_o | output | 1 | Enable delivered to the downstream peripheral |

## Verification
The divider is driven with configurations of several kinds:
- N=0 and M=0, the fastest rate.
- The reset word.
- Words that vary only N, and words that vary only M.
- A large M.
- A word whose reserved bits are all set.

The N-only and M-only cases tell apart the power-of-two stage from the modulo stage, and catch swapped or misplaced fields. For each configuration, the first pulse after the write and the following pulse interval are both measured. This separates a correct restart from a counter that keeps its old phase. A rewrite of an unchanged value in mid-period confirms that the restart does not depend on the value changing. The largest N confirms that the power-of-two stage spans its full counter width.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    parameter int CFG_W  = 32;
    parameter int M_W    = 12;
    parameter int N_W    = 4;
    parameter int N_LSB  = M_W;
    parameter int USED_W = N_W + M_W;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } div_cfg_t;

    localparam logic [N_W-1:0] RST_N_VAL = N_W'(1);
    localparam logic [M_W-1:0] RST_M_VAL = M_W'(9);

    function automatic div_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        div_cfg_t c;
        c.n = w[N_LSB +: N_W];
        c.m = w[0 +: M_W];
        return c;
    endfunction

endpackage

// File: rtl/prescale_cfg_reg.sv
module prescale_cfg_reg
    import prescaler_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_word,
    output div_cfg_t         cfg
);

    typedef struct packed {
        div_cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = unpack_cfg(wr_word);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.n <= RST_N_VAL;
            st_q.cfg.m <= RST_M_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

endmodule

// File: rtl/prescale_pow2_stage.sv
module prescale_pow2_stage #(
    parameter int N_W = 4,
    localparam int CNT_W = 1 << N_W,
    localparam int SH_W  = N_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic [N_W-1:0] n_sel,
    output logic           term
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        // Terminal count is 2^(N+1)-1; a shift of CNT_W leaves all ones.
        shamt = {1'b0, n_sel} + SH_W'(1);
        limit = ~({CNT_W{1'b1}} << shamt);
        term  = (st_q.cnt == limit);
        st_d  = st_q;
        if (restart || term) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/prescale_mod_stage.sv
module prescale_mod_stage #(
    parameter int M_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           step,
    input  logic [M_W-1:0] m_sel,
    output logic           term
);

    typedef struct packed {
        logic [M_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        term = (st_q.cnt == m_sel);
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = term ? '0 : st_q.cnt + M_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import prescaler_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             use_prescaled,
    output logic             tick_o,
    output logic             periph_en_o
);

    typedef struct packed {
        logic tick;
    } state_t;

    state_t   st_d, st_q;
    div_cfg_t cfg;
    logic     pow_term;
    logic     mod_term;

    prescale_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_word (cfg_wdata),
        .cfg     (cfg)
    );

    prescale_pow2_stage #(.N_W(N_W)) u_pow2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .n_sel   (cfg.n),
        .term    (pow_term)
    );

    prescale_mod_stage #(.M_W(M_W)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .step    (pow_term),
        .m_sel   (cfg.m),
        .term    (mod_term)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = pow_term && mod_term && !cfg_we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (CFG_W > USED_W) begin : g_pad
            assign cfg_rdata = {{(CFG_W-USED_W){1'b0}}, cfg};
        end else begin : g_nopad
            assign cfg_rdata = CFG_W'(cfg);
        end
    endgenerate

    assign tick_o      = st_q.tick;
    assign periph_en_o = use_prescaled ? st_q.tick : 1'b1;

endmodule

// File: rtl/tick_prescaler_chk.sv
module tick_prescaler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        use_prescaled,
    input logic        tick_o,
    input logic        periph_en_o
);

    p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !tick_o);

    p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == {16'h0000, $past(cfg_wdata[15:0])}));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    p_fastest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !cfg_we && cfg_rdata[15:0] == 16'h0000) |=> (!tick_o && !cfg_we) |=> tick_o);

    p_raw_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !use_prescaled |-> periph_en_o);

endmodule

bind tick_prescaler tick_prescaler_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .use_prescaled (use_prescaled),
    .tick_o        (tick_o),
    .periph_en_o   (periph_en_o)
);

// File: tb/test_tick_prescaler.sv
`timescale 1ns/1ps
module test_tick_prescaler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        use_prescaled = 1'b1;
    logic        tick_o;
    logic        periph_en_o;

    int n_total = 0;
    int n_fail  = 0;

    localparam int NV = 8;
    localparam logic [31:0] VEC_CFG [NV] = '{
        32'h0000_0000,   // R7 fastest
        32'h0000_1009,   // reset word
        32'hFFFF_0002,   // R5 reserved bits set
        32'h0000_2003,   // N=2 M=3
        32'h0000_1A21,   // R10 M=2593
        32'h0000_4000,   // N=4 M=0
        32'h0000_6000,   // N=6 M=0
        32'h0000_407C    // N=4 M=124
    };
    localparam int VEC_PER [NV] = '{2, 40, 6, 32, 10376, 32, 128, 4000};
    localparam logic [31:0] VEC_RB [NV] = '{
        32'h0, 32'h1009, 32'h0002, 32'h2003, 32'h1A21, 32'h4000, 32'h6000, 32'h407C
    };

    tick_prescaler i_tick_prescaler (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .use_prescaled (use_prescaled),
        .tick_o        (tick_o),
        .periph_en_o   (periph_en_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // counts rising edges until tick_o is seen just after an edge
    task automatic wait_tick(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            #1;
            cyc++;
        end while (!tick_o && cyc < 70000);
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        int c2;
        bit ok;
        bit seen;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(cfg_rdata == 32'h0000_1009, "R1 reset readback", cfg_rdata, 32'h1009);
        chk(tick_o == 1'b0, "R1 tick low in reset", tick_o, 0);

        // R9: first tick after release at edge 40
        @(negedge clk);
        rst_n = 1'b1;
        wait_tick(c);
        chk(c == 40, "R9 first period after reset", c, 40);

        // Vector table: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC_CFG[i]);
            chk(cfg_rdata == VEC_RB[i], "R6 readback", cfg_rdata, VEC_RB[i]);
            wait_tick(c);
            chk(c == VEC_PER[i], "R4 first tick after write", c, VEC_PER[i]);
            @(posedge clk);
            #1;
            chk(tick_o == 1'b0, "R3 single-cycle tick", tick_o, 0);
            wait_tick(c2);
            c2 = c2 + 1;
            chk(c2 == VEC_PER[i], "R2 steady period", c2, VEC_PER[i]);
        end

        // R4: rewrite same value mid-period restarts phase
        write_cfg(32'h0000_1009);
        repeat (15) @(posedge clk);
        write_cfg(32'h0000_1009);
        wait_tick(c);
        chk(c == 40, "R4 rewrite restarts", c, 40);

        // R8: raw select keeps enable high; prescaled select follows tick
        @(negedge clk);
        use_prescaled = 1'b0;
        ok = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 90; k++) begin
            @(posedge clk);
            #1;
            if (periph_en_o !== 1'b1) ok = 1'b0;
            if (tick_o) seen = 1'b1;
        end
        chk(ok && seen, "R8 raw select enable high", {ok, seen}, 3);
        @(negedge clk);
        use_prescaled = 1'b1;
        ok = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 90; k++) begin
            @(posedge clk);
            #1;
            if (periph_en_o !== tick_o) ok = 1'b0;
            if (periph_en_o) seen = 1'b1;
        end
        chk(ok && seen, "R8 prescaled select follows tick", {ok, seen}, 3);

        // R7: direct run of N=0 M=0 checked cycle by cycle
        write_cfg(32'h0000_0000);
        ok = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            #1;
            if (tick_o !== ((k % 2) == 0)) ok = 1'b0;
        end
        chk(ok, "R7 every second cycle", ok, 1);

        // R10: largest N
        write_cfg(32'h0000_F000);
        wait_tick(c);
        chk(c == 65536, "R10 N=15 period", c, 65536);

        finish_run();
    end

endmodule